// File: doc/BRIEF.md
# Transfer Start Address Generator

This block turns the addressing fields a host has written into a disk task file into the byte offset at which a sector transfer begins. A single-cycle start strobe captures the drive/head byte, the two cylinder bytes, the sector number, the drive geometry (heads and sectors per track) and the block size. The block then works out the block number, either by joining the fields directly as a 28-bit logical block number or by converting a cylinder/head/sector triple. It scales the result by the block size on a shared serial multiplier and reports completion with a one-cycle done pulse.

Once an address has been produced, every block-done strobe moves it forward by the captured block size, so the transfer sequencer always reads the byte offset of the next block here. A cylinder/head/sector request against a drive whose head count or sector count is zero produces no address and raises an error flag instead. Command decode and transfer sequencing are handled outside this block.

Top module: `xfer_addr_gen`

## Requirements
- R1: After reset, busy_o, done_o, addr_valid_o, chs_err_o and drive_sel_o are 0 and byte_addr_o is 0.
- R2: A start_i seen while busy_o is 0 raises busy_o on the next cycle. Completion is signalled by done_o high for exactly one cycle, in the same cycle that busy_o returns to 0. While idle, byte_addr_o, addr_valid_o and drive_sel_o hold their values unless start_i or blk_done_i is high.
- R3: At completion, drive_sel_o equals bit 4 of the captured drive/head byte (1 selects the second drive).
- R4: When bit 6 of the drive/head byte is 1 (logical mode), byte_addr_o = {drive_head[3:0], cyl_hi, cyl_lo, sec_num} × block size, and addr_valid_o is 1.
- R5: When bit 6 is 0 (geometry mode) and the geometry is non-zero, byte_addr_o = (((({cyl_hi,cyl_lo} × heads + drive_head[3:0]) × sectors_per_track + sec_num − 1) mod 2^28) × block size, and addr_valid_o is 1. A sector number of 0 therefore wraps the block number modulo 2^28.
- R6: In geometry mode with heads = 0 or sectors_per_track = 0, completion sets chs_err_o to 1, addr_valid_o to 0 and byte_addr_o to 0. The next start clears the error.
- R7: A blk_done_i while idle with addr_valid_o at 1 adds the block size captured at start to byte_addr_o on the next cycle. Changing blk_bytes_i after the start has no effect on that step.
- R8: The following have no effect on the outputs: start_i and blk_done_i while busy_o is 1, blk_done_i while chs_err_o is 1, and changes to the inputs after a start.
- R9: byte_addr_o is 28 + BSZ_W bits wide, so the largest logical block (0xFFFFFFF) times the largest block size (2^BSZ_W − 1) is produced without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the fields and compute a new start address |
| blk_done_i | input | 1 | One block finished; advance the address |
| drv_head_i | input | 8 | Drive/head byte: bit 6 mode, bit 4 drive, bits 3:0 head or top block bits |
| cyl_hi_i | input | 8 | Cylinder high byte |
| cyl_lo_i | input | 8 | Cylinder low byte |
| sec_num_i | input | 8 | Sector number byte |
| heads_i | input | GEO_W | Heads per cylinder of the selected drive |
| spt_i | input | GEO_W | Sectors per track of the selected drive |
| blk_bytes_i | input | BSZ_W | Block size in bytes |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| byte_addr_o | output | 28+BSZ_W | Current byte address |
| addr_valid_o | output | 1 | byte_addr_o holds a computed address |
| chs_err_o | output | 1 | Geometry-mode request with zero geometry |
| drive_sel_o | output | 1 | Selected drive index |

## Verification
A corrupted sequencing state shows as a missing or doubled done pulse, or as busy_o that never falls. A slip in a multiplier step or an operand shows up as a wrong byte_addr_o at the done pulse. That value is compared at once, about 45 cycles after start in geometry mode and about 16 in logical mode. A wrong captured block size or a wrong guard on the advance path shows on the first blk_done_i, one cycle later. Busy-time strobes and late input changes are applied during a computation so that any leak reaches the result it produces.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
    localparam int TF_W    = 8;   // task-file byte width
    localparam int LBA_W   = 28;  // logical block number width
    localparam int HEAD_W  = 4;   // head / top block bits in drive-head byte
    localparam int CYL_W   = 2 * TF_W;
    localparam int MODE_BIT = 6;  // 1: logical addressing
    localparam int DRV_BIT  = 4;  // 1: second drive

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_MUL_CH,
        ST_MUL_SP,
        ST_MUL_BY
    } seq_state_t;
endpackage

// File: rtl/tf_field_decode.sv
module tf_field_decode
    import addr_gen_pkg::*;
#(
    parameter int GEO_W = 8
) (
    input  logic [TF_W-1:0]   dh_i,
    input  logic [TF_W-1:0]   ch_i,
    input  logic [TF_W-1:0]   cl_i,
    input  logic [TF_W-1:0]   sn_i,
    input  logic [GEO_W-1:0]  heads_i,
    input  logic [GEO_W-1:0]  spt_i,
    output logic              lba_mode_o,
    output logic              drive_o,
    output logic [HEAD_W-1:0] head_o,
    output logic [CYL_W-1:0]  cyl_o,
    output logic [LBA_W-1:0]  lba_blk_o,
    output logic              geom_zero_o
);
    logic unused_dh_bits;

    always_comb begin
        lba_mode_o  = dh_i[MODE_BIT];
        drive_o     = dh_i[DRV_BIT];
        head_o      = dh_i[HEAD_W-1:0];
        cyl_o       = {ch_i, cl_i};
        lba_blk_o   = {dh_i[HEAD_W-1:0], ch_i, cl_i, sn_i};
        geom_zero_o = (heads_i == '0) || (spt_i == '0);
    end

    assign unused_dh_bits = ^{dh_i[7], dh_i[5]};
endmodule

// File: rtl/serial_mac.sv
// res = a * b + c (mod 2^AW), one multiplier bit per cycle, LSB first.
module serial_mac #(
    parameter int AW = 42,
    parameter int BW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    input  logic [AW-1:0] c_i,
    output logic          rdy_o,
    output logic [AW-1:0] res_o
);
    localparam int CW = $clog2(BW + 1);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] a_sh;
        logic [BW-1:0] b_sh;
        logic [CW-1:0] cnt;
        logic          run;
        logic          rdy;
    } mac_t;

    mac_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.rdy = 1'b0;
        if (go_i) begin
            m_d.acc  = c_i;
            m_d.a_sh = a_i;
            m_d.b_sh = b_i;
            m_d.cnt  = CW'(BW);
            m_d.run  = 1'b1;
        end else if (m_q.run) begin
            if (m_q.b_sh[0]) begin
                m_d.acc = m_q.acc + m_q.a_sh;
            end
            m_d.a_sh = m_q.a_sh << 1;
            m_d.b_sh = m_q.b_sh >> 1;
            m_d.cnt  = m_q.cnt - CW'(1);
            if (m_q.cnt == CW'(1)) begin
                m_d.run = 1'b0;
                m_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign rdy_o = m_q.rdy;
    assign res_o = m_q.acc;
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
    import addr_gen_pkg::*;
#(
    parameter int BSZ_W = 14,
    parameter int GEO_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   blk_done_i,
    input  logic [TF_W-1:0]        drv_head_i,
    input  logic [TF_W-1:0]        cyl_hi_i,
    input  logic [TF_W-1:0]        cyl_lo_i,
    input  logic [TF_W-1:0]        sec_num_i,
    input  logic [GEO_W-1:0]       heads_i,
    input  logic [GEO_W-1:0]       spt_i,
    input  logic [BSZ_W-1:0]       blk_bytes_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [LBA_W+BSZ_W-1:0] byte_addr_o,
    output logic                   addr_valid_o,
    output logic                   chs_err_o,
    output logic                   drive_sel_o
);
    localparam int AW = LBA_W + BSZ_W;
    localparam int BW = (BSZ_W > GEO_W) ? BSZ_W : GEO_W;

    typedef struct packed {
        seq_state_t       st;
        logic [TF_W-1:0]  dh;
        logic [TF_W-1:0]  ch;
        logic [TF_W-1:0]  cl;
        logic [TF_W-1:0]  sn;
        logic [GEO_W-1:0] heads;
        logic [GEO_W-1:0] spt;
        logic [BSZ_W-1:0] bytes;
        logic [AW-1:0]    blk;
        logic [AW-1:0]    addr;
        logic             valid;
        logic             err;
        logic             drv;
        logic             done;
        logic             go;
    } regs_t;

    regs_t r_d, r_q;

    logic              dec_lba;
    logic              dec_drive;
    logic [HEAD_W-1:0] dec_head;
    logic [CYL_W-1:0]  dec_cyl;
    logic [LBA_W-1:0]  dec_lba_blk;
    logic              dec_geom_zero;

    logic [AW-1:0]     mac_a;
    logic [BW-1:0]     mac_b;
    logic [AW-1:0]     mac_c;
    logic              mac_rdy;
    logic [AW-1:0]     mac_res;
    logic [BSZ_W-1:0]  bytes_lat;

    tf_field_decode #(.GEO_W(GEO_W)) u_dec (
        .dh_i        (r_q.dh),
        .ch_i        (r_q.ch),
        .cl_i        (r_q.cl),
        .sn_i        (r_q.sn),
        .heads_i     (r_q.heads),
        .spt_i       (r_q.spt),
        .lba_mode_o  (dec_lba),
        .drive_o     (dec_drive),
        .head_o      (dec_head),
        .cyl_o       (dec_cyl),
        .lba_blk_o   (dec_lba_blk),
        .geom_zero_o (dec_geom_zero)
    );

    // Operand selection for the shared multiplier, keyed by the step.
    always_comb begin
        mac_a = '0;
        mac_b = '0;
        mac_c = '0;
        unique case (r_q.st)
            ST_MUL_CH: begin
                mac_a = AW'(dec_cyl);
                mac_b = BW'(r_q.heads);
                mac_c = AW'(dec_head);
            end
            ST_MUL_SP: begin
                mac_a = r_q.blk;
                mac_b = BW'(r_q.spt);
                mac_c = AW'(r_q.sn) - AW'(1);
            end
            ST_MUL_BY: begin
                mac_a = AW'(r_q.blk[LBA_W-1:0]);
                mac_b = BW'(r_q.bytes);
            end
            default: ;
        endcase
    end

    serial_mac #(.AW(AW), .BW(BW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (r_q.go),
        .a_i   (mac_a),
        .b_i   (mac_b),
        .c_i   (mac_c),
        .rdy_o (mac_rdy),
        .res_o (mac_res)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.go   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.dh    = drv_head_i;
                    r_d.ch    = cyl_hi_i;
                    r_d.cl    = cyl_lo_i;
                    r_d.sn    = sec_num_i;
                    r_d.heads = heads_i;
                    r_d.spt   = spt_i;
                    r_d.bytes = blk_bytes_i;
                    r_d.valid = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.st    = ST_DECODE;
                end else if (blk_done_i && r_q.valid) begin
                    r_d.addr = r_q.addr + AW'(r_q.bytes);
                end
            end
            ST_DECODE: begin
                if (!dec_lba && dec_geom_zero) begin
                    r_d.addr  = '0;
                    r_d.valid = 1'b0;
                    r_d.err   = 1'b1;
                    r_d.drv   = dec_drive;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end else if (dec_lba) begin
                    r_d.blk = AW'(dec_lba_blk);
                    r_d.go  = 1'b1;
                    r_d.st  = ST_MUL_BY;
                end else begin
                    r_d.go = 1'b1;
                    r_d.st = ST_MUL_CH;
                end
            end
            ST_MUL_CH: begin
                if (mac_rdy) begin
                    r_d.blk = mac_res;
                    r_d.go  = 1'b1;
                    r_d.st  = ST_MUL_SP;
                end
            end
            ST_MUL_SP: begin
                if (mac_rdy) begin
                    r_d.blk = AW'(mac_res[LBA_W-1:0]);
                    r_d.go  = 1'b1;
                    r_d.st  = ST_MUL_BY;
                end
            end
            ST_MUL_BY: begin
                if (mac_rdy) begin
                    r_d.addr  = mac_res;
                    r_d.valid = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.drv   = dec_drive;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign byte_addr_o  = r_q.addr;
    assign addr_valid_o = r_q.valid;
    assign chs_err_o    = r_q.err;
    assign drive_sel_o  = r_q.drv;
    assign bytes_lat    = r_q.bytes;
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
    parameter int BSZ_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               blk_done_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [28+BSZ_W-1:0] byte_addr_o,
    input logic               addr_valid_o,
    input logic               chs_err_o,
    input logic               drive_sel_o,
    input logic [BSZ_W-1:0]   bytes_lat
);
    localparam int AW = 28 + BSZ_W;

    // R2: an accepted start makes the block busy next cycle
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2: done coincides with idle and lasts one cycle
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: idle outputs hold with no strobe
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !blk_done_i)
        |=> ($stable(byte_addr_o) && $stable(addr_valid_o) && $stable(drive_sel_o)));

    // R6: an error never carries an address
    p_err_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chs_err_o |-> (!addr_valid_o && byte_addr_o == '0));

    // R7: advance by the captured block size
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && blk_done_i && addr_valid_o)
        |=> (byte_addr_o == ($past(byte_addr_o) + AW'($past(bytes_lat)))));

    // R8: block-done during an error leaves the address at zero
    p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chs_err_o && !start_i && blk_done_i) |=> (byte_addr_o == '0));
endmodule

bind xfer_addr_gen addr_gen_chk #(.BSZ_W(BSZ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .blk_done_i   (blk_done_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .byte_addr_o  (byte_addr_o),
    .addr_valid_o (addr_valid_o),
    .chs_err_o    (chs_err_o),
    .drive_sel_o  (drive_sel_o),
    .bytes_lat    (bytes_lat)
);

// File: tb/tb_xfer_addr_gen.sv
module tb_xfer_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BSZ_W = 14;
    localparam int GEO_W = 8;
    localparam int AW = 28 + BSZ_W;
    localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic blk_done_i = 1'b0;
    logic [7:0] drv_head_i = '0, cyl_hi_i = '0, cyl_lo_i = '0, sec_num_i = '0;
    logic [GEO_W-1:0] heads_i = '0, spt_i = '0;
    logic [BSZ_W-1:0] blk_bytes_i = '0;
    logic busy_o, done_o, addr_valid_o, chs_err_o, drive_sel_o;
    logic [AW-1:0] byte_addr_o;

    int errors = 0;
    int checks = 0;
    logic [BSZ_W-1:0] last_bytes;
    bit last_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_addr_gen #(.BSZ_W(BSZ_W), .GEO_W(GEO_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_done_i(blk_done_i),
        .drv_head_i(drv_head_i), .cyl_hi_i(cyl_hi_i), .cyl_lo_i(cyl_lo_i),
        .sec_num_i(sec_num_i), .heads_i(heads_i), .spt_i(spt_i),
        .blk_bytes_i(blk_bytes_i), .busy_o(busy_o), .done_o(done_o),
        .byte_addr_o(byte_addr_o), .addr_valid_o(addr_valid_o),
        .chs_err_o(chs_err_o), .drive_sel_o(drive_sel_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_addr(input logic [7:0] dh, input logic [7:0] ch,
        input logic [7:0] cl, input logic [7:0] sn, input logic [7:0] h, input logic [7:0] s,
        input logic [13:0] b);
        logic [63:0] blk;
        if (dh[6]) blk = {36'd0, dh[3:0], ch, cl, sn};
        else blk = (({48'd0, ch, cl} * {56'd0, h} + {60'd0, dh[3:0]}) * {56'd0, s})
                   + {56'd0, sn} - 64'd1;
        blk = blk & 64'h0FFF_FFFF;
        return (blk * {50'd0, b}) & AMASK;
    endfunction

    task automatic run_op(input logic [7:0] dh, input logic [7:0] ch, input logic [7:0] cl,
        input logic [7:0] sn, input logic [7:0] h, input logic [7:0] s,
        input logic [13:0] b, input bit disturb);
        bit e_err;
        int n;
        e_err = !dh[6] && (h == 0 || s == 0);
        @(negedge clk);
        drv_head_i = dh; cyl_hi_i = ch; cyl_lo_i = cl; sec_num_i = sn;
        heads_i = h; spt_i = s; blk_bytes_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", {63'd0, busy_o}, 64'd1);
        if (disturb) begin
            // R8: strobes and new inputs while busy must not change the result
            drv_head_i = ~dh; cyl_hi_i = ~ch; sec_num_i = sn + 8'd3;
            heads_i = h + 8'd1; blk_bytes_i = ~b;
            start_i = 1'b1; blk_done_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; blk_done_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R2 done seen", {63'd0, done_o}, 64'd1);
        check("R2 idle at done", {63'd0, busy_o}, 64'd0);
        check("R3 drive select", {63'd0, drive_sel_o}, {63'd0, dh[4]});
        check(e_err ? "R6 error flag" : "R4/R5 error flag", {63'd0, chs_err_o}, {63'd0, e_err});
        check(e_err ? "R6 no valid" : "R4/R5 valid", {63'd0, addr_valid_o}, {63'd0, !e_err});
        check(e_err ? "R6 zero address" : (dh[6] ? "R4 logical address" : "R5 geometry address"),
              {22'd0, byte_addr_o}, e_err ? 64'd0 : exp_addr(dh, ch, cl, sn, h, s, b));
        @(negedge clk);
        check("R2 done single cycle", {63'd0, done_o}, 64'd0);
        last_bytes = b;
        last_err = e_err;
    endtask

    task automatic step_blk();
        logic [63:0] prev;
        prev = {22'd0, byte_addr_o};
        blk_bytes_i = ~last_bytes;  // R7: late size change is ignored
        blk_done_i = 1'b1;
        @(negedge clk);
        blk_done_i = 1'b0;
        if (last_err)
            check("R8 step ignored in error", {22'd0, byte_addr_o}, 64'd0);
        else
            check("R7 advance by block size", {22'd0, byte_addr_o},
                  (prev + {50'd0, last_bytes}) & AMASK);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {63'd0, busy_o}, 64'd0);
        check("R1 done", {63'd0, done_o}, 64'd0);
        check("R1 addr", {22'd0, byte_addr_o}, 64'd0);
        check("R1 valid", {63'd0, addr_valid_o}, 64'd0);
        check("R1 err", {63'd0, chs_err_o}, 64'd0);
        check("R1 drive", {63'd0, drive_sel_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 and R9: largest logical block times largest block size
        run_op(8'h5F, 8'hFF, 8'hFF, 8'hFF, 8'd0, 8'd0, 14'h3FFF, 1'b0);
        step_blk();
        // R4: simple logical block, drive 0
        run_op(8'h40, 8'h00, 8'h01, 8'h02, 8'd16, 8'd63, 14'd512, 1'b0);
        step_blk();
        step_blk();
        // R5: geometry mode, sector 1 at origin gives block 0
        run_op(8'h00, 8'h00, 8'h00, 8'h01, 8'd16, 8'd63, 14'd512, 1'b0);
        // R5: sector 0 wraps modulo 2^28
        run_op(8'h10, 8'h00, 8'h00, 8'h00, 8'd4, 8'd8, 14'd2, 1'b0);
        // R5: large geometry
        run_op(8'h1F, 8'hFF, 8'hFF, 8'hFF, 8'd255, 8'd255, 14'd4096, 1'b0);
        step_blk();
        // R6: zero heads, then zero sectors per track
        run_op(8'h13, 8'h01, 8'h02, 8'h05, 8'd0, 8'd63, 14'd512, 1'b0);
        step_blk();
        run_op(8'h03, 8'h01, 8'h02, 8'h05, 8'd16, 8'd0, 14'd512, 1'b0);
        // R8: strobes while busy, in both modes
        run_op(8'h02, 8'h12, 8'h34, 8'h09, 8'd15, 8'd17, 14'd1024, 1'b1);
        step_blk();
        run_op(8'h57, 8'hAB, 8'hCD, 8'hEF, 8'd1, 8'd1, 14'd300, 1'b1);

        for (int i = 0; i < 150; i++) begin
            logic [7:0] dh, h, s;
            logic [13:0] b;
            dh = 8'($urandom);
            h = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom);
            s = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom);
            b = ($urandom_range(0, 3) == 0) ? 14'd512 : 14'($urandom);
            run_op(dh, 8'($urandom), 8'($urandom), 8'($urandom), h, s, b,
                   ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 1) == 1) step_blk();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule